// File: doc/BRIEF.md
# Slot-Wheel and Round-Robin Bus Arbiter

This block decides, every clock cycle, which of several initiators may drive a shared on-chip bus. Each decision runs in two phases. First a rotating time-slot wheel names a reserved owner for the current cycle. If that slot is assigned and its owner is requesting, the owner wins; this gives each owner a guaranteed share of the bus and a bounded wait. If the slot is unassigned, or its owner is idle, the cycle falls through to a round-robin pass over all requesters, which serves random traffic fairly.

The wheel holds a programmable number of entries. Each entry carries an owner index and an assigned flag. A slot pointer steps through the wheel by one entry per active cycle. Software fills the wheel while a hold input keeps arbitration switched off, then releases the hold. The grant is one-hot and registered. A companion flag tells the bus whether the grant came from a reserved slot or from the round-robin pass.

Top module: `slot_wheel_arbiter`

## Requirements
- R1: After reset, the grant is all zeros, the reserved flag is 0, the slot pointer is at entry 0, every wheel entry is unassigned, and the first round-robin search starts at requester 0.
- R2: A wheel write (`tbl_wr_en` high) stores `tbl_wr_owner` and `tbl_wr_valid` into entry `tbl_wr_idx` only while `arb_off` is high. A write issued while `arb_off` is low changes nothing.
- R3: While `arb_off` is high, no grant is issued and the slot pointer returns to entry 0. The first decision after `arb_off` falls therefore uses entry 0.
- R4: On every clock edge with `arb_off` low, the slot pointer advances by one entry and wraps from NUM_SLOTS-1 to 0.
- R5: When the current entry is assigned and its owner requests, that owner is granted and `grant_reserved` is 1.
- R6: Otherwise the first requester after the last round-robin winner, in increasing index order with wrap-around, is granted and `grant_reserved` is 0.
- R7: The last round-robin winner is updated only by round-robin grants. Reserved-slot grants and idle cycles leave it unchanged.
- R8: A cycle with no request line high produces no grant.
- R9: The decision for the `req` value present at clock edge k appears on `grant` right after edge k. At most one grant bit is set, and only for a requester that was high at that edge.
- R10: A requester that requests continuously sees fewer than NUM_REQ round-robin grants to other initiators between its own grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_off | input | 1 | Holds arbitration off; wheel writes are accepted only while high |
| req | input | NUM_REQ | Request lines, one per initiator |
| tbl_wr_en | input | 1 | Wheel entry write strobe |
| tbl_wr_idx | input | clog2(NUM_SLOTS) | Entry to write |
| tbl_wr_owner | input | clog2(NUM_REQ) | Owner index for the written entry |
| tbl_wr_valid | input | 1 | Assigned flag for the written entry |
| grant | output | NUM_REQ | Registered one-hot grant |
| grant_reserved | output | 1 | 1 when the grant came from the reserved slot phase |

## Verification
The hardest situation to reach from the ports is an assigned slot whose owner is idle while other initiators request. Only this case shows whether the fall-through keeps the round-robin pointer consistent. It needs the wheel phase and the request pattern aligned in the same cycle. The bench programs a wheel with assigned entries, unassigned entries and repeated owners. It then sweeps request patterns built from a cycle counter, so every pattern meets every wheel entry across the laps. A reference model in the bench tracks the slot pointer and the last round-robin winner by arithmetic.

// File: rtl/swarb_pkg.sv
package swarb_pkg;

  // Next position on a ring of n entries.
  function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Position step places after base on a ring of n entries (step <= n).
  function automatic int unsigned ring_index(int unsigned base, int unsigned step,
                                             int unsigned n);
    int unsigned s;
    s = base + step;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/swarb_slot_table.sv
module swarb_slot_table #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_off,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [IDX_W-1:0]  wr_owner,
  input  logic              wr_valid,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [IDX_W-1:0]  cur_owner,
  output logic              cur_valid
);
  import swarb_pkg::*;

  logic [NUM_SLOTS-1:0][IDX_W-1:0] owner_q;
  logic [NUM_SLOTS-1:0]            valid_q;
  logic [NUM_SLOTS-1:0]            entry_hit;
  logic [SLOT_W-1:0]               slot_q;
  logic                            wr_ok;

  // Writes land only while arbitration is held off.
  assign wr_ok = wr_en && arb_off;

  for (genvar e = 0; e < NUM_SLOTS; e++) begin : g_hit
    assign entry_hit[e] = wr_ok && (wr_idx == SLOT_W'(e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      valid_q <= '0;
    end else begin
      for (int e = 0; e < NUM_SLOTS; e++) begin
        if (entry_hit[e]) begin
          owner_q[e] <= wr_owner;
          valid_q[e] <= wr_valid;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (arb_off) slot_q <= '0;
    else              slot_q <= SLOT_W'(wrap_next(32'(slot_q), NUM_SLOTS));
  end

  assign cur_slot  = slot_q;
  assign cur_owner = owner_q[slot_q];
  assign cur_valid = valid_q[slot_q];

endmodule

// File: rtl/swarb_rr_select.sv
module swarb_rr_select #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic [IDX_W-1:0]   last,
  output logic               found,
  output logic [IDX_W-1:0]   win
);
  import swarb_pkg::*;

  logic [IDX_W-1:0] pos;

  // Scan from farthest to nearest so the nearest requester after last wins.
  always_comb begin
    found = 1'b0;
    win   = '0;
    pos   = '0;
    for (int k = NUM_REQ; k >= 1; k--) begin
      pos = IDX_W'(ring_index(32'(last), k, NUM_REQ));
      if (req[pos]) begin
        found = 1'b1;
        win   = pos;
      end
    end
  end

endmodule

// File: rtl/slot_wheel_arbiter.sv
module slot_wheel_arbiter #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_off,
  input  logic [NUM_REQ-1:0] req,
  input  logic               tbl_wr_en,
  input  logic [SLOT_W-1:0]  tbl_wr_idx,
  input  logic [IDX_W-1:0]   tbl_wr_owner,
  input  logic               tbl_wr_valid,
  output logic [NUM_REQ-1:0] grant,
  output logic               grant_reserved
);

  logic [SLOT_W-1:0]  cur_slot;
  logic [IDX_W-1:0]   cur_owner;
  logic               cur_valid;
  logic               rr_found;
  logic [IDX_W-1:0]   rr_win;
  logic [IDX_W-1:0]   rr_last_q;
  logic               tdma_hit;
  logic               rr_hit;
  logic [NUM_REQ-1:0] grant_d;
  logic [NUM_REQ-1:0] grant_q;
  logic               rsv_q;

  swarb_slot_table #(.NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_off   (arb_off),
    .wr_en     (tbl_wr_en),
    .wr_idx    (tbl_wr_idx),
    .wr_owner  (tbl_wr_owner),
    .wr_valid  (tbl_wr_valid),
    .cur_slot  (cur_slot),
    .cur_owner (cur_owner),
    .cur_valid (cur_valid)
  );

  swarb_rr_select #(.NUM_REQ(NUM_REQ)) u_rr (
    .req   (req),
    .last  (rr_last_q),
    .found (rr_found),
    .win   (rr_win)
  );

  // Phase one: reserved slot owner; phase two: round-robin fall-through.
  assign tdma_hit = !arb_off && cur_valid && (32'(cur_owner) < NUM_REQ) && req[cur_owner];
  assign rr_hit   = !arb_off && !tdma_hit && rr_found;

  always_comb begin
    grant_d = '0;
    if (tdma_hit)    grant_d[cur_owner] = 1'b1;
    else if (rr_hit) grant_d[rr_win]    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q   <= '0;
      rsv_q     <= 1'b0;
      rr_last_q <= IDX_W'(NUM_REQ - 1);
    end else begin
      grant_q <= grant_d;
      rsv_q   <= tdma_hit;
      if (rr_hit) rr_last_q <= rr_win;
    end
  end

  assign grant          = grant_q;
  assign grant_reserved = rsv_q;

endmodule

// File: rtl/swarb_checker.sv
module swarb_checker #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arb_off,
  input logic [NUM_REQ-1:0] req,
  input logic [NUM_REQ-1:0] grant,
  input logic               grant_reserved,
  input logic [IDX_W-1:0]   rr_last,
  input logic [SLOT_W-1:0]  slot_ptr
);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_off |=> ((grant & ~$past(req)) == '0));

  // R3
  off_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_off |=> (grant == '0 && !grant_reserved && slot_ptr == '0));

  // R8
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_off && req == '0) |=> (grant == '0));

  // R5
  reserved_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_reserved |-> (grant != '0));

  // R7
  rr_hold_on_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_reserved |-> (rr_last == $past(rr_last)));

  // R4
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_off && slot_ptr == SLOT_W'(NUM_SLOTS - 1)) |=> (slot_ptr == '0));

  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_off && slot_ptr != SLOT_W'(NUM_SLOTS - 1)) |=> (slot_ptr == $past(slot_ptr) + 1'b1));

endmodule

bind slot_wheel_arbiter swarb_checker #(.NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .arb_off        (arb_off),
  .req            (req),
  .grant          (grant),
  .grant_reserved (grant_reserved),
  .rr_last        (rr_last_q),
  .slot_ptr       (cur_slot)
);

// File: tb/sim_slot_wheel_arbiter.sv
`timescale 1ns/1ps
module sim_slot_wheel_arbiter;
  localparam int M = 4;
  localparam int S = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arb_off = 1'b1;
  logic [M-1:0] req = '0;
  logic         tbl_wr_en = 1'b0;
  logic [2:0]   tbl_wr_idx = '0;
  logic [1:0]   tbl_wr_owner = '0;
  logic         tbl_wr_valid = 1'b0;
  logic [M-1:0] grant;
  logic         grant_reserved;

  int checks = 0;
  int errors = 0;

  // Reference state, restated by arithmetic.
  int m_owner [S];
  bit m_valid [S];
  int m_slot;
  int m_last;
  int waits [M];
  int worst_wait;
  int owner0_slots;
  int owner0_hits;
  bit track_owner0;

  always #4 clk = ~clk;

  slot_wheel_arbiter #(.NUM_REQ(M), .NUM_SLOTS(S)) u0 (
    .clk(clk), .rst_n(rst_n), .arb_off(arb_off), .req(req),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_owner(tbl_wr_owner),
    .tbl_wr_valid(tbl_wr_valid), .grant(grant), .grant_reserved(grant_reserved)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic step(input logic off, input logic [M-1:0] r, input logic we,
                      input int wi, input int wo, input logic wv, input string tag);
    logic [M-1:0] eg;
    logic         er;
    int           win;
    eg = '0; er = 1'b0; win = -1;
    if (!off) begin
      if (m_valid[m_slot] && r[m_owner[m_slot]]) begin
        eg[m_owner[m_slot]] = 1'b1;
        er = 1'b1;
      end else begin
        for (int k = 1; k <= M; k++) begin
          int idx;
          idx = (m_last + k) % M;
          if (win < 0 && r[idx]) win = idx;
        end
        if (win >= 0) eg[win] = 1'b1;
      end
    end
    arb_off = off; req = r; tbl_wr_en = we;
    tbl_wr_idx = 3'(wi); tbl_wr_owner = 2'(wo); tbl_wr_valid = wv;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant !== eg || grant_reserved !== er) begin
      errors++;
      $display("FAIL %s: slot %0d req %b grant %b/%b expected %b/%b",
               tag, m_slot, r, grant, grant_reserved, eg, er);
    end
    if (track_owner0 && !off && m_valid[m_slot] && m_owner[m_slot] == 0) begin
      owner0_slots++;
      if (grant[0] === 1'b1 && grant_reserved === 1'b1) owner0_hits++;
    end
    // advance model
    if (off) begin
      m_slot = 0;
      if (we) begin m_owner[wi] = wo; m_valid[wi] = wv; end
    end else begin
      m_slot = (m_slot + 1) % S;
      if (win >= 0) begin
        m_last = win;
        for (int i = 0; i < M; i++) begin
          if (i == win || !r[i]) waits[i] = 0;
          else begin
            waits[i]++;
            if (waits[i] > worst_wait) worst_wait = waits[i];
          end
        end
      end
    end
    tbl_wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < S; i++) begin m_owner[i] = 0; m_valid[i] = 0; end
    for (int i = 0; i < M; i++) waits[i] = 0;
    m_slot = 0; m_last = M - 1; worst_wait = 0;
    owner0_slots = 0; owner0_hits = 0; track_owner0 = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (grant !== '0 || grant_reserved !== 1'b0) begin
      errors++;
      $display("FAIL R1: grant %b/%b expected 0000/0", grant, grant_reserved);
    end
    rst_n = 1'b1;

    // R1: empty wheel, round-robin begins at requester 0
    step(0, 4'b1111, 0, 0, 0, 0, "R1");
    step(0, 4'b1111, 0, 0, 0, 0, "R1 R6");
    step(0, 4'b1010, 0, 0, 0, 0, "R6");
    // R8: idle cycles, then the round-robin pointer must not have moved (R7)
    for (int i = 0; i < 5; i++) step(0, 4'b0000, 0, 0, 0, 0, "R8");
    step(0, 4'b1111, 0, 0, 0, 0, "R7 R8");

    // R3: hold arbitration off; requests ignored
    for (int i = 0; i < 3; i++) step(1, 4'b1111, 0, 0, 0, 0, "R3");
    // R2: program wheel while off (owner 0 twice, three unassigned entries)
    step(1, 4'b1111, 1, 0, 0, 1, "R2 R3");
    step(1, 4'b0000, 1, 1, 1, 1, "R2");
    step(1, 4'b0000, 1, 3, 3, 1, "R2");
    step(1, 4'b0000, 1, 4, 0, 1, "R2");
    step(1, 4'b0000, 1, 6, 2, 1, "R2");

    // R3 R4 R5: first enabled decision uses entry 0
    step(0, 4'b0001, 0, 0, 0, 0, "R3 R5");
    // R2: write while enabled must be ignored (entry 2 stays unassigned)
    step(0, 4'b0000, 1, 2, 1, 1, "R2");
    step(0, 4'b0110, 0, 0, 0, 0, "R2 R6");
    for (int i = 0; i < 13; i++) step(0, 4'b0010, 0, 0, 0, 0, "R2 R4 R5 R6");

    // R5 R6 R7: sweep every request pattern against every wheel entry
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pv;
      pv = 8'(p);
      step(0, pv[3:0] ^ pv[7:4] ^ {pv[0], pv[2], pv[1], pv[3]}, 0, 0, 0, 0, "R5 R6 R7");
    end

    // R5: owner 0 requests continuously and must win each of its slots
    track_owner0 = 1;
    for (int p = 0; p < 64; p++) begin
      logic [3:0] pv;
      pv = 4'(p * 5 + 3);
      step(0, pv | 4'b0001, 0, 0, 0, 0, "R5");
    end
    track_owner0 = 0;
    checks++;
    if (owner0_hits != owner0_slots || owner0_slots == 0) begin
      errors++;
      $display("FAIL R5: owner slot grants %0d expected %0d", owner0_hits, owner0_slots);
    end

    // R10: everyone requests; round-robin waits bounded
    for (int i = 0; i < M; i++) waits[i] = 0;
    worst_wait = 0;
    for (int p = 0; p < 96; p++) step(0, 4'b1111, 0, 0, 0, 0, "R10");
    checks++;
    if (worst_wait >= M) begin
      errors++;
      $display("FAIL R10: worst round-robin wait %0d expected below %0d", worst_wait, M);
    end

    // R3 R4: reprogram mid-lap, wheel restarts at entry 0
    step(1, 4'b1111, 1, 0, 3, 1, "R3");
    step(1, 4'b0000, 1, 7, 1, 1, "R2");
    for (int p = 0; p < 24; p++) step(0, 4'(p ^ 9), 0, 0, 0, 0, "R4 R5 R6");

    summary();
    $finish;
  end

endmodule